// File: doc/BRIEF.md
# FIFO Trigger and Interrupt Controller

This block sits between a processor register port and a serial shift engine. It holds two byte-wide queues of the same depth: an outgoing queue that the processor fills and the engine drains, and an incoming queue that the engine fills and the processor drains. Each queue has a programmable threshold. When the incoming queue holds at least its threshold, the block flags "receive ready". When the outgoing queue holds no more than its threshold, the block flags "transmit request". Each of these flags drives an interrupt status bit and, if enabled, a DMA request line.

Four 32-bit registers are selected by a 2-bit index: queue control (0), queue occupancy (1), interrupt enable (2) and interrupt status (3). Status bits are cleared by writing a one to them. Overflow of the incoming queue and a transfer-complete pulse from the engine are also recorded in the status register. The single interrupt line is the OR of all enabled pending bits. The depth parameter must be a power of two no larger than 128; 64 and 128 are the intended sizes.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset, all four registers read 0, and `irq`, `rx_dma_req` and `tx_dma_req` are 0.
- R2: Each queue returns bytes in the order they were written. Register 1 reports the incoming count in bits 7:0 and the outgoing count in bits 23:16.
- R3: An engine push while the incoming queue is full sets status bit 8 (overflow) on the next cycle. The byte is dropped, and both the count and the stored contents are unchanged.
- R4: The receive-ready condition is incoming count >= control bits 7:0. While it holds, status bit 0 is set one cycle later. `rx_dma_req` equals the condition ANDed with control bit 8.
- R5: The transmit-request condition is outgoing count <= control bits 23:16. While it holds, status bit 4 is set one cycle later. `tx_dma_req` equals the condition ANDed with control bit 24.
- R6: Writing register 3 clears each status bit whose written bit is 1. Written zeros leave bits unchanged. Bits 0 and 4 stay set if their condition holds during the clearing write.
- R7: A one-cycle `xfer_done` pulse sets status bit 12 on the next cycle.
- R8: Register 2 holds enables at bits 0, 4, 8 and 12 (other bits read 0). `irq` is high whenever some status bit and its enable are both 1.
- R9: Writing control register 0 with bit 15 set empties the incoming queue, and with bit 31 set empties the outgoing queue, both in that write's cycle. These two bits always read back as 0, and the other fields of the same write still take effect.
- R10: A processor push into a full outgoing queue is dropped. A pop from an empty queue leaves its count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register index (0 control, 1 occupancy, 2 enable, 3 status) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data of the selected register |
| cpu_tx_push | input | 1 | Processor push into the outgoing queue |
| cpu_tx_data | input | 8 | Byte to push |
| cpu_rx_pop | input | 1 | Processor pop from the incoming queue |
| cpu_rx_data | output | 8 | Head byte of the incoming queue |
| eng_tx_pop | input | 1 | Engine pop from the outgoing queue |
| eng_tx_data | output | 8 | Head byte of the outgoing queue |
| eng_tx_empty | output | 1 | Outgoing queue is empty |
| eng_rx_push | input | 1 | Engine push into the incoming queue |
| eng_rx_data | input | 8 | Byte to push |
| xfer_done | input | 1 | Transfer-complete pulse from the engine |
| irq | output | 1 | Interrupt |
| rx_dma_req | output | 1 | Incoming-queue DMA request |
| tx_dma_req | output | 1 | Outgoing-queue DMA request |

## Verification
The case that is hardest to reach from the ports is a clearing write to a level-style status bit at the exact moment its condition changes. The bench first sets the threshold so that the condition holds and shows that the clear has no effect. It then moves the count across the threshold with a single push, and clears again on the following cycle. The threshold comparisons are swept over every level from 0 to the depth against every occupancy, on a depth-8 instance.

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [1:0]  csr_sel,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        cpu_tx_push,
  input  logic [7:0]  cpu_tx_data,
  input  logic        cpu_rx_pop,
  output logic [7:0]  cpu_rx_data,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_data,
  output logic        eng_tx_empty,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_data,
  input  logic        xfer_done,
  output logic        irq,
  output logic        rx_dma_req,
  output logic        tx_dma_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    rx_lvl, tx_lvl;
  logic          rx_dma_en, tx_dma_en;
  logic [3:0]    ie, st;
  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire wr_ctl = csr_we && csr_sel == 2'd0;
  wire wr_ie  = csr_we && csr_sel == 2'd2;
  wire wr_st  = csr_we && csr_sel == 2'd3;
  wire rx_flush = wr_ctl && csr_wdata[15];
  wire tx_flush = wr_ctl && csr_wdata[31];

  wire tx_in  = cpu_tx_push && tx_cnt != FULL;
  wire tx_out = eng_tx_pop  && tx_cnt != '0;
  wire rx_in  = eng_rx_push && rx_cnt != FULL;
  wire rx_out = cpu_rx_pop  && rx_cnt != '0;
  wire rx_ovf = eng_rx_push && rx_cnt == FULL;

  wire [7:0] rx_cnt8 = 8'(rx_cnt);
  wire [7:0] tx_cnt8 = 8'(tx_cnt);
  wire rx_cond = rx_cnt8 >= rx_lvl;
  wire tx_cond = tx_cnt8 <= tx_lvl;

  wire [3:0] clr = wr_st ? {csr_wdata[12], csr_wdata[8], csr_wdata[4], csr_wdata[0]} : 4'b0;
  wire [3:0] hit = {xfer_done, rx_ovf, tx_cond, rx_cond};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_lvl <= '0; tx_lvl <= '0; rx_dma_en <= 1'b0; tx_dma_en <= 1'b0;
      ie <= '0; st <= '0;
    end else begin
      if (wr_ctl) begin
        rx_lvl    <= csr_wdata[7:0];
        rx_dma_en <= csr_wdata[8];
        tx_lvl    <= csr_wdata[23:16];
        tx_dma_en <= csr_wdata[24];
      end
      if (wr_ie) ie <= {csr_wdata[12], csr_wdata[8], csr_wdata[4], csr_wdata[0]};
      st <= hit | (st & ~clr);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_in && !tx_flush) tx_mem[tx_wp] <= cpu_tx_data;
    if (rx_in && !rx_flush) rx_mem[rx_wp] <= eng_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      tx_wp  <= tx_wp + AW'(tx_in);
      tx_rp  <= tx_rp + AW'(tx_out);
      tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_out);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      rx_wp  <= rx_wp + AW'(rx_in);
      rx_rp  <= rx_rp + AW'(rx_out);
      rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
    end
  end

  function automatic logic [31:0] spread(input logic [3:0] b);
    return {19'b0, b[3], 3'b0, b[2], 3'b0, b[1], 3'b0, b[0]};
  endfunction

  always_comb begin
    case (csr_sel)
      2'd0:    csr_rdata = {7'b0, tx_dma_en, tx_lvl, 7'b0, rx_dma_en, rx_lvl};
      2'd1:    csr_rdata = {8'b0, tx_cnt8, 8'b0, rx_cnt8};
      2'd2:    csr_rdata = spread(ie);
      default: csr_rdata = spread(st);
    endcase
  end

  assign eng_tx_data  = tx_mem[tx_rp];
  assign cpu_rx_data  = rx_mem[rx_rp];
  assign eng_tx_empty = tx_cnt == '0;
  assign irq          = |(st & ie);
  assign rx_dma_req   = rx_cond && rx_dma_en;
  assign tx_dma_req   = tx_cond && tx_dma_en;
endmodule

// File: rtl/fifo_irq_chk.sv
module fifo_irq_chk #(
  parameter int DEPTH = 64,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csr_we,
  input logic [1:0]    csr_sel,
  input logic [31:0]   csr_wdata,
  input logic          eng_rx_push,
  input logic          cpu_rx_pop,
  input logic          xfer_done,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic [7:0]    rx_lvl,
  input logic [7:0]    tx_lvl,
  input logic [3:0]    st,
  input logic          rx_dma_req,
  input logic          tx_dma_req
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  wire [7:0] rc = 8'(rx_cnt);
  wire [7:0] tc = 8'(tx_cnt);
  wire rxf = csr_we && csr_sel == 2'd0 && csr_wdata[15];
  wire txf = csr_we && csr_sel == 2'd0 && csr_wdata[31];

  a_r3_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_push && rx_cnt == FULL |=> st[2]);
  a_r3_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_push && !cpu_rx_pop && !rxf && rx_cnt == FULL |=> rx_cnt == FULL);
  a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL && tx_cnt <= FULL);
  a_r4_rdy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rc >= rx_lvl |=> st[0]);
  a_r4_rx_req: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> rc >= rx_lvl);
  a_r5_treq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tc <= tx_lvl |=> st[1]);
  a_r5_tx_req: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> tc <= tx_lvl);
  a_r6_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    st[2] && !(csr_we && csr_sel == 2'd3 && csr_wdata[8]) |=> st[2]);
  a_r7_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> st[3]);
  a_r9_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    rxf |=> rx_cnt == '0);
  a_r9_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    txf |=> tx_cnt == '0);
endmodule

bind fifo_irq_ctrl fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
  .eng_rx_push(eng_rx_push), .cpu_rx_pop(cpu_rx_pop), .xfer_done(xfer_done),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_lvl(rx_lvl), .tx_lvl(tx_lvl), .st(st),
  .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
);

// File: tb/sim_fifo_irq_ctrl.sv
module sim_fifo_irq_ctrl;
  localparam int D = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_we = 1'b0; logic [1:0] csr_sel = 2'd0; logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic cpu_tx_push = 1'b0; logic [7:0] cpu_tx_data = '0;
  logic cpu_rx_pop = 1'b0;  logic [7:0] cpu_rx_data;
  logic eng_tx_pop = 1'b0;  logic [7:0] eng_tx_data; logic eng_tx_empty;
  logic eng_rx_push = 1'b0; logic [7:0] eng_rx_data = '0;
  logic xfer_done = 1'b0;
  logic irq, rx_dma_req, tx_dma_req;
  int nchk = 0, nerr = 0;
  bit fin = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  fifo_irq_ctrl #(.DEPTH(D)) u0 (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    csr_we = 1'b1; csr_sel = s; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask
  task automatic rd(input logic [1:0] s, output logic [31:0] r);
    csr_sel = s; #1; r = csr_rdata;
  endtask
  task automatic txpush(input logic [7:0] d);
    cpu_tx_push = 1'b1; cpu_tx_data = d; @(negedge clk); cpu_tx_push = 1'b0;
  endtask
  task automatic txpop();
    eng_tx_pop = 1'b1; @(negedge clk); eng_tx_pop = 1'b0;
  endtask
  task automatic rxpush(input logic [7:0] d);
    eng_rx_push = 1'b1; eng_rx_data = d; @(negedge clk); eng_rx_push = 1'b0;
  endtask
  task automatic rxpop();
    cpu_rx_pop = 1'b1; @(negedge clk); cpu_rx_pop = 1'b0;
  endtask
  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
  endtask

  function automatic logic [7:0] pa(input int i); return 8'((i * 37 + 5) & 255); endfunction
  function automatic logic [7:0] pb(input int i); return 8'((i * 91 + 17) & 255); endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      nerr++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v); check("R1 reset register", v, 0);
    end
    check("R1 reset irq", {29'b0, irq, rx_dma_req, tx_dma_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < D; i++) begin
      rd(1, v); check("R2 tx count", (v >> 16) & 255, i);
      txpush(pa(i));
    end
    rd(1, v); check("R2 tx count full", (v >> 16) & 255, D);
    txpush(8'h99);
    rd(1, v); check("R10 push into full tx dropped", (v >> 16) & 255, D);
    for (int i = 0; i < D; i++) begin
      check("R2 tx order", eng_tx_data, pa(i));
      txpop();
    end
    txpop();
    rd(1, v); check("R10 pop empty tx", (v >> 16) & 255, 0);
    check("R10 tx empty flag", eng_tx_empty, 1);

    for (int lvl = 0; lvl <= D; lvl++) begin
      wr(0, 32'h8100_0000 | (lvl << 16));
      rd(0, v); check("R9 tx reset bit reads 0", v, 32'h0100_0000 | (lvl << 16));
      for (int c = 0; c <= D; c++) begin
        check("R5 tx dma request", tx_dma_req, (c <= lvl) ? 1 : 0);
        if (c < D) txpush(pa(c));
      end
    end
    wr(0, 32'h8000_0000);
    rd(1, v); check("R9 tx flush", (v >> 16) & 255, 0);
    check("R5 tx dma disabled", tx_dma_req, 0);

    for (int lvl = 0; lvl <= D; lvl++) begin
      wr(0, 32'h0000_8100 | lvl);
      rd(0, v); check("R9 rx reset bit reads 0", v, 32'h0000_0100 | lvl);
      for (int c = 0; c <= D; c++) begin
        check("R4 rx dma request", rx_dma_req, (c >= lvl) ? 1 : 0);
        if (c < D) rxpush(pb(c));
      end
    end
    wr(0, 32'h0000_8000);
    rd(1, v); check("R9 rx flush", v & 255, 0);
    check("R4 rx dma disabled", rx_dma_req, 0);
    wr(3, 32'hFFFF_FFFF);

    for (int i = 0; i < D; i++) rxpush(pb(i + 3));
    rxpush(8'hEE);
    rd(3, v); check("R3 overflow flag", (v >> 8) & 1, 1);
    rd(1, v); check("R3 count unchanged", v & 255, D);
    for (int i = 0; i < D; i++) begin
      check("R3 R2 rx order, dropped byte absent", cpu_rx_data, pb(i + 3));
      rxpop();
    end
    rxpop();
    rd(1, v); check("R10 pop empty rx", v & 255, 0);

    wr(3, 32'h0);
    rd(3, v); check("R6 zero write keeps overflow", (v >> 8) & 1, 1);
    wr(3, 32'h100);
    rd(3, v); check("R6 overflow cleared", (v >> 8) & 1, 0);

    wr(3, 32'h10);
    rd(3, v); check("R6 level bit held while condition", (v >> 4) & 1, 1);
    txpush(8'h01);
    wr(3, 32'h10);
    rd(3, v); check("R6 level bit clears once condition gone", (v >> 4) & 1, 0);
    wr(0, 32'h8000_0003);
    @(negedge clk);
    wr(3, 32'h1);
    rd(3, v); check("R4 ready clear below level", v & 1, 0);
    rxpush(8'h10); rxpush(8'h11);
    @(negedge clk);
    rd(3, v); check("R4 ready not set at count 2", v & 1, 0);
    rxpush(8'h12);
    @(negedge clk);
    rd(3, v); check("R4 ready set at count 3", v & 1, 1);
    rd(3, v); check("R5 request flag with empty tx", (v >> 4) & 1, 1);

    wr(3, 32'h1000);
    rd(3, v); check("R7 done clear", (v >> 12) & 1, 0);
    wr(2, 32'h1000);
    check("R8 irq quiet", irq, 0);
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    rd(3, v); check("R7 done set", (v >> 12) & 1, 1);
    check("R8 irq from done", irq, 1);
    wr(2, 32'h0);
    check("R8 irq masked", irq, 0);
    wr(3, 32'hFFFF_FFFF);
    rd(3, v); check("R6 clear all keeps level bits", v, 32'h11);
    wr(2, 32'h10);
    check("R8 irq from request", irq, 1);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); check("R8 enable readback", v, 32'h1111);

    fin = 1;
    summary();
    $finish;
  end
endmodule